// File: doc/BRIEF.md
# Snapshot Scan-Set Register

This block pairs a bank of functional storage with a shadow chain of equal width. The shadow chain can be loaded serially from a scan input and read serially at a scan output. It can copy the whole functional bank in one cycle, which freezes a picture of the live state without stopping it. It can also push its own contents into the functional bank in one cycle, which places a chosen test state into the running logic. When no test control is active, the functional bank captures its data input like an ordinary register.

All four operations are enables sampled on one rising clock edge. A decoder turns the enables into two per-cycle operating modes, one for each storage side, and each edge picks both modes afresh. Any mode can follow any other. The system side has three modes. SYS_HOLD is the default. SYS_CAPTURE applies when capture is enabled and update is not. SYS_UPDATE applies whenever update is enabled. The shadow side also has three modes. SH_HOLD is the default. SH_SHIFT applies when shift is enabled and snapshot is not. SH_SNAP applies whenever snapshot is enabled. Because both sides read values from before the edge, a snapshot and an update in the same cycle swap the two registers.

Top module: `snapshot_scanset`

## Requirements
- R1: While `rst_n` is low, `sys_q` and every shadow cell are 0, so `scan_out` is 0.
- R2: With `shift_en` high and `snap_en` low, cell 0 takes `scan_in` and each cell i>0 takes cell i-1. `scan_out` always shows the highest-index cell, so a bit entered on a shift edge reaches `scan_out` after WIDTH shift edges in total.
- R3: With `update_en` high, `sys_q` bit i takes shadow cell i from before the edge.
- R4: With `snap_en` high, shadow cell i takes `sys_q` bit i from before the edge.
- R5: With `func_cap_en` high and `update_en` low, `sys_q` takes `func_d` at the edge.
- R6: When `update_en` and `func_cap_en` are both high, the update wins and `func_d` is ignored.
- R7: When `snap_en` and `shift_en` are both high, the snapshot wins and `scan_in` is ignored.
- R8: A shift with neither `update_en` nor `func_cap_en` high leaves `sys_q` unchanged.
- R9: A functional capture with neither `snap_en` nor `shift_en` high leaves the shadow chain unchanged. This is seen later by shifting the chain out.
- R10: A snapshot and a functional capture in the same cycle give the shadow the pre-edge `sys_q`, while `sys_q` still takes `func_d`. Taking the snapshot does not disturb functional capture.
- R11: With all four enables low, both `sys_q` and the shadow chain keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for all storage |
| rst_n | input | 1 | Asynchronous active-low reset |
| func_d | input | WIDTH | Functional data into the system bank |
| func_cap_en | input | 1 | Functional capture enable |
| update_en | input | 1 | Parallel shadow-to-system transfer |
| snap_en | input | 1 | Parallel system-to-shadow snapshot |
| shift_en | input | 1 | Serial shift of the shadow chain |
| scan_in | input | 1 | Serial data into shadow cell 0 |
| scan_out | output | 1 | Last shadow cell |
| sys_q | output | WIDTH | System bank contents |

## Verification
The bench builds the block with WIDTH set to 6. This is wide enough that a shifted bit passes through four interior cells before it reaches `scan_out`, and wide enough that asymmetric patterns reveal a reversed or offset cell mapping in the parallel transfers. It is also short enough that a snapshot can be shifted out completely many times within the run. Directed phases cover the conflicting-enable cases: update with capture, snapshot with shift, and snapshot with capture. A long stretch of random enables then drives every pair of system and shadow modes against the behavioural model.

// File: rtl/ssr_pkg.sv
package ssr_pkg;

    typedef enum logic [1:0] {
        SYS_HOLD    = 2'd0,
        SYS_CAPTURE = 2'd1,
        SYS_UPDATE  = 2'd2
    } sys_mode_e;

    typedef enum logic [1:0] {
        SH_HOLD  = 2'd0,
        SH_SHIFT = 2'd1,
        SH_SNAP  = 2'd2
    } sh_mode_e;

endpackage

// File: rtl/ssr_mode_decode.sv
module ssr_mode_decode
    import ssr_pkg::*;
(
    input  logic      func_cap_en,
    input  logic      update_en,
    input  logic      snap_en,
    input  logic      shift_en,
    output sys_mode_e sys_mode,
    output sh_mode_e  sh_mode
);

    // System side: a parallel transfer from the shadow outranks functional capture.
    always_comb begin
        if (update_en)        sys_mode = SYS_UPDATE;
        else if (func_cap_en) sys_mode = SYS_CAPTURE;
        else                  sys_mode = SYS_HOLD;
    end

    // Shadow side: a snapshot outranks serial shifting.
    always_comb begin
        if (snap_en)       sh_mode = SH_SNAP;
        else if (shift_en) sh_mode = SH_SHIFT;
        else               sh_mode = SH_HOLD;
    end

endmodule

// File: rtl/ssr_system_bank.sv
module ssr_system_bank
    import ssr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  sys_mode_e        mode,
    input  logic [WIDTH-1:0] func_d,
    input  logic [WIDTH-1:0] shadow_q,
    output logic [WIDTH-1:0] sys_q
);

    logic [WIDTH-1:0] sys_next;

    always_comb begin
        unique case (mode)
            SYS_CAPTURE: sys_next = func_d;
            SYS_UPDATE:  sys_next = shadow_q;
            default:     sys_next = sys_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sys_q <= '0;
        else        sys_q <= sys_next;
    end

endmodule

// File: rtl/ssr_shadow_chain.sv
module ssr_shadow_chain
    import ssr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  sh_mode_e         mode,
    input  logic             scan_in,
    input  logic [WIDTH-1:0] sys_q,
    output logic [WIDTH-1:0] shadow_q
);

    logic [WIDTH-1:0] shifted;
    logic [WIDTH-1:0] shadow_next;

    generate
        if (WIDTH == 1) begin : g_single
            assign shifted = scan_in;
        end else begin : g_multi
            assign shifted = {shadow_q[WIDTH-2:0], scan_in};
        end
    endgenerate

    always_comb begin
        unique case (mode)
            SH_SHIFT: shadow_next = shifted;
            SH_SNAP:  shadow_next = sys_q;
            default:  shadow_next = shadow_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shadow_q <= '0;
        else        shadow_q <= shadow_next;
    end

endmodule

// File: rtl/snapshot_scanset.sv
module snapshot_scanset
    import ssr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] func_d,
    input  logic             func_cap_en,
    input  logic             update_en,
    input  logic             snap_en,
    input  logic             shift_en,
    input  logic             scan_in,
    output logic             scan_out,
    output logic [WIDTH-1:0] sys_q
);

    sys_mode_e        sys_mode;
    sh_mode_e         sh_mode;
    logic [WIDTH-1:0] shadow_q;

    ssr_mode_decode u_decode (
        .func_cap_en (func_cap_en),
        .update_en   (update_en),
        .snap_en     (snap_en),
        .shift_en    (shift_en),
        .sys_mode    (sys_mode),
        .sh_mode     (sh_mode)
    );

    ssr_system_bank #(.WIDTH(WIDTH)) u_sys (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (sys_mode),
        .func_d   (func_d),
        .shadow_q (shadow_q),
        .sys_q    (sys_q)
    );

    ssr_shadow_chain #(.WIDTH(WIDTH)) u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (sh_mode),
        .scan_in  (scan_in),
        .sys_q    (sys_q),
        .shadow_q (shadow_q)
    );

    assign scan_out = shadow_q[WIDTH-1];

endmodule

// File: rtl/ssr_chk.sv
module ssr_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] func_d,
    input logic             func_cap_en,
    input logic             update_en,
    input logic             snap_en,
    input logic             shift_en,
    input logic             scan_in,
    input logic [WIDTH-1:0] sys_q,
    input logic [WIDTH-1:0] shadow_q
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |-> (sys_q == '0 && shadow_q == '0));

    // R2
    shift_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !snap_en) |=> shadow_q[0] == $past(scan_in));

    // R3 R6
    update_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        update_en |=> sys_q == $past(shadow_q));

    // R4 R7 R10
    snap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snap_en |=> shadow_q == $past(sys_q));

    // R5 R10
    func_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (func_cap_en && !update_en) |=> sys_q == $past(func_d));

    // R8 R11
    sys_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!update_en && !func_cap_en) |=> $stable(sys_q));

    // R9 R11
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!snap_en && !shift_en) |=> $stable(shadow_q));

endmodule

bind snapshot_scanset ssr_chk #(.WIDTH(WIDTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .func_d      (func_d),
    .func_cap_en (func_cap_en),
    .update_en   (update_en),
    .snap_en     (snap_en),
    .shift_en    (shift_en),
    .scan_in     (scan_in),
    .sys_q       (sys_q),
    .shadow_q    (shadow_q)
);

// File: tb/snapshot_scanset_test.sv
`timescale 1ns/1ps
module snapshot_scanset_test;

    localparam int W = 6;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] func_d = '0;
    logic         func_cap_en = 1'b0;
    logic         update_en = 1'b0;
    logic         snap_en = 1'b0;
    logic         shift_en = 1'b0;
    logic         scan_in = 1'b0;
    logic         scan_out;
    logic [W-1:0] sys_q;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // Behavioural reference: element 0 of the queue is the cell nearest scan_in.
    bit           sh_m[$];
    logic [W-1:0] sys_m;

    always #4 clk = ~clk;

    snapshot_scanset #(.WIDTH(W)) uut (
        .clk(clk), .rst_n(rst_n), .func_d(func_d), .func_cap_en(func_cap_en),
        .update_en(update_en), .snap_en(snap_en), .shift_en(shift_en),
        .scan_in(scan_in), .scan_out(scan_out), .sys_q(sys_q)
    );

    task automatic compare(input string tag);
        checks++;
        if (sys_q !== sys_m) begin
            fails++;
            $display("FAIL %s sys_q actual=%h expected=%h", tag, sys_q, sys_m);
        end
        checks++;
        if (scan_out !== sh_m[W-1]) begin
            fails++;
            $display("FAIL %s scan_out actual=%b expected=%b", tag, scan_out, sh_m[W-1]);
        end
    endtask

    task automatic model_edge();
        logic [W-1:0] old_sys;
        bit old_sh[$];
        old_sys = sys_m;
        old_sh = sh_m;
        if (update_en) begin
            for (int i = 0; i < W; i++) sys_m[i] = old_sh[i];
        end else if (func_cap_en) begin
            sys_m = func_d;
        end
        if (snap_en) begin
            for (int i = 0; i < W; i++) sh_m[i] = old_sys[i];
        end else if (shift_en) begin
            sh_m.push_front(scan_in);
            void'(sh_m.pop_back());
        end
    endtask

    task automatic cyc(input logic [W-1:0] d, input bit cap, input bit upd,
                       input bit snp, input bit sh, input bit si, input string tag);
        func_d = d; func_cap_en = cap; update_en = upd;
        snap_en = snp; shift_en = sh; scan_in = si;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        sys_m = '0;
        for (int i = 0; i < W; i++) sh_m.push_back(1'b0);
        repeat (2) @(negedge clk);
        compare("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1 after release");

        cyc(6'h2D, 1, 0, 0, 0, 0, "R5 capture");
        // Load the pattern 1,0,1,1,0,0 serially; the system bank must not move.
        cyc(6'h3F, 0, 0, 0, 1, 1, "R2 R8 shift");
        cyc(6'h3F, 0, 0, 0, 1, 0, "R2 R8 shift");
        cyc(6'h3F, 0, 0, 0, 1, 1, "R2 R8 shift");
        cyc(6'h3F, 0, 0, 0, 1, 1, "R2 R8 shift");
        cyc(6'h3F, 0, 0, 0, 1, 0, "R2 R8 shift");
        cyc(6'h3F, 0, 0, 0, 1, 0, "R2 R8 shift");
        cyc(6'h15, 0, 0, 0, 0, 1, "R11 idle");
        cyc(6'h00, 0, 1, 0, 0, 0, "R3 update");
        cyc(6'h2A, 0, 0, 0, 0, 0, "R11 idle");
        cyc(6'h21, 1, 1, 0, 0, 0, "R6 update over capture");
        cyc(6'h07, 1, 0, 0, 0, 0, "R9 capture only");
        cyc(6'h38, 1, 0, 1, 0, 0, "R10 snapshot with capture");
        for (int i = 0; i < W; i++) cyc(6'h00, 0, 0, 0, 1, i[0], "R4 R2 unload");
        cyc(6'h19, 1, 0, 0, 0, 0, "R5 capture");
        cyc(6'h00, 0, 0, 1, 1, 1, "R7 snapshot over shift");
        for (int i = 0; i < W; i++) cyc(6'h00, 0, 0, 0, 1, 0, "R7 R2 unload");
        cyc(6'h0B, 1, 0, 0, 0, 0, "R9 capture only");
        for (int i = 0; i < W; i++) cyc(6'h00, 0, 0, 0, 1, 1, "R9 R2 unload");
        cyc(6'h12, 1, 1, 1, 0, 0, "R3 R4 swap");

        for (int n = 0; n < 400; n++) begin
            logic [31:0] r;
            r = $urandom;
            cyc(r[W-1:0], r[8], r[9] & r[10], r[11], r[12], r[13], "R2 R3 R4 R5 mixed");
        end

        rst_n = 1'b0;
        sys_m = '0;
        for (int i = 0; i < W; i++) sh_m[i] = 1'b0;
        @(negedge clk);
        compare("R1 mid-run reset");
        finish_run();
    end

endmodule